// File: doc/BRIEF.md
# One-Shot Fault Suppression Controller

This block holds four single-use fault-disable bits of a processor status word. Each bit masks one class of fault for exactly one instruction, or for one mandatory register-stack memory reference, and then clears itself. Software arms the bits by placing them in the saved status copy. A return-from-interruption strobe then loads that copy into the live bits.

The live bits are cleared by different events. A successful instruction clears all four. A successful register-stack memory reference clears the two data bits. Entry into the variable-length instruction mode clears every bit except instruction-debug. A small two-state machine tracks that entry. A return-from-interruption or a mode-switch branch moves it from `ST_SETTLED` to `ST_ENTRY_PEND` (transition `T_ARM`). In the next cycle it samples the mode bit:
- If the mode bit is high, it moves back to `ST_SETTLED` and clears the three entry bits (transition `T_FLUSH`).
- If the mode bit is low, it moves back to `ST_SETTLED` and clears nothing (transition `T_BUNDLED`).

A further arm while in `ST_ENTRY_PEND` keeps the machine there (transition `T_REARM`).

The per-class mask outputs are combinational decodes of the live bits. Fault detection and the register stack engine are outside this block.

Top module: `fault_oneshot_ctrl`

## Requirements
- R1: After reset all four live bits and all mask outputs are 0.
- R2: A cycle with `ret_load` high makes the live bits equal to `ret_bits` after that clock edge. The bit order is: bit 0 instruction-debug, bit 1 data-access, bit 2 instruction-access, bit 3 data-debug.
- R3: A cycle with `insn_done` high and `insn_fault` low clears all four live bits, unless `ret_load` is also high in that cycle.
- R4: A cycle with `stk_done` high and `stk_fault` low clears bits 1 and 3 and leaves bits 0 and 2 unchanged, unless `ret_load` is also high in that cycle.
- R5: A completion that reports a fault (`insn_fault` or `stk_fault` high) leaves the live bits unchanged.
- R6: When `ret_load` coincides with a successful completion strobe, the live bits take `ret_bits`.
- R7: In the cycle after a `ret_load` or `mode_br` strobe, if `var_mode` is high, bits 1, 2 and 3 are cleared at the end of that cycle and bit 0 keeps its value.
- R8: If `var_mode` is low in the cycle after a `ret_load` or `mode_br` strobe, nothing is cleared and the pending entry is dropped. A later rise of `var_mode` without a new strobe clears nothing.
- R9: The masks follow the live bits in the same cycle: `mask_insn_dbg` = bit 0, `mask_insn_acc` = bit 2, `mask_dirty` = `mask_data_acc` = bit 1, `mask_data_dbg` = bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_load | input | 1 | Return-from-interruption strobe |
| ret_bits | input | 4 | Saved-copy disable bits loaded on `ret_load` |
| insn_done | input | 1 | Instruction completion strobe |
| insn_fault | input | 1 | Completing instruction raised a fault |
| stk_done | input | 1 | Mandatory register-stack memory reference completed |
| stk_fault | input | 1 | That reference raised a fault |
| mode_br | input | 1 | Mode-switch branch strobe |
| var_mode | input | 1 | 1 = variable-length instruction mode, 0 = bundled mode |
| live_bits | output | 4 | Current disable bits |
| mask_insn_dbg | output | 1 | Suppress instruction debug fault |
| mask_insn_acc | output | 1 | Suppress instruction access-bit fault |
| mask_dirty | output | 1 | Suppress dirty-bit fault |
| mask_data_acc | output | 1 | Suppress data access-bit fault |
| mask_data_dbg | output | 1 | Suppress data debug fault |

## Verification
The hardest case to reach is the entry flush. It needs a strobe followed by exactly one cycle in which the mode bit is sampled. The bench reaches it twice:
- Once by returning with the mode bit already high.
- Once by first settling in bundled mode, then raising the mode bit and pulsing the mode-switch branch.

The bench also shows that raising the mode bit without a strobe does nothing.

// File: rtl/fos_pkg.sv
package fos_pkg;
    localparam int NBITS      = 4;
    localparam int IDX_IDBG   = 0;
    localparam int IDX_DACC   = 1;
    localparam int IDX_IACC   = 2;
    localparam int IDX_DDBG   = 3;
    // Bits cleared by a successful register-stack reference.
    localparam logic [NBITS-1:0] STK_CLR_SET   = (1 << IDX_DACC) | (1 << IDX_DDBG);
    // Bits cleared on entry to the variable-length mode.
    localparam logic [NBITS-1:0] ENTRY_CLR_SET = (1 << IDX_DACC) | (1 << IDX_IACC) | (1 << IDX_DDBG);

    typedef enum logic {
        ST_SETTLED    = 1'b0,
        ST_ENTRY_PEND = 1'b1
    } entry_state_e;
endpackage

// File: rtl/fos_entry_fsm.sv
module fos_entry_fsm
    import fos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic var_mode,
    output logic entry_clr
);
    entry_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLED:    if (arm) state_d = ST_ENTRY_PEND;   // T_ARM
            ST_ENTRY_PEND: if (arm) state_d = ST_ENTRY_PEND;   // T_REARM
                           else     state_d = ST_SETTLED;      // T_FLUSH / T_BUNDLED
            default:       state_d = ST_SETTLED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SETTLED;
        else        state_q <= state_d;
    end

    always_comb begin
        entry_clr = 1'b0;
        unique case (state_q)
            ST_SETTLED:    entry_clr = 1'b0;
            ST_ENTRY_PEND: entry_clr = var_mode;
            default:       entry_clr = 1'b0;
        endcase
    end

    // R7/R8: a strobe always opens exactly one sampling cycle
    p_arm_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> state_q == ST_ENTRY_PEND);
    p_pend_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTRY_PEND && !arm) |=> state_q == ST_SETTLED);
endmodule

// File: rtl/fos_bit_bank.sv
module fos_bit_bank
    import fos_pkg::*;
#(
    parameter int W = NBITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         insn_ok,
    input  logic         stk_ok,
    input  logic         entry_clr,
    output logic [W-1:0] bits
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic clr;
        assign clr = insn_ok | (stk_ok & STK_CLR_SET[g]) | (entry_clr & ENTRY_CLR_SET[g]);
        always_ff @(posedge clk) begin
            if (!rst_n)    bits[g] <= 1'b0;
            else if (load) bits[g] <= load_val[g];
            else if (clr)  bits[g] <= 1'b0;
        end
    end

    p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> bits == $past(load_val));
    p_insn_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_ok && !load) |=> bits == '0);
    p_stk_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_ok && !load) |=> (bits & STK_CLR_SET) == '0);
    p_quiet_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !insn_ok && !stk_ok && !entry_clr) |=> $stable(bits));
    p_entry_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_clr && !load) |=> (bits & ENTRY_CLR_SET) == '0);
    p_entry_keeps_idbg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_clr && !load && !insn_ok) |=> bits[IDX_IDBG] == $past(bits[IDX_IDBG]));
endmodule

// File: rtl/fos_mask_map.sv
module fos_mask_map
    import fos_pkg::*;
(
    input  logic [NBITS-1:0] bits,
    output logic             m_insn_dbg,
    output logic             m_insn_acc,
    output logic             m_dirty,
    output logic             m_data_acc,
    output logic             m_data_dbg
);
    always_comb begin
        m_insn_dbg = bits[IDX_IDBG];
        m_insn_acc = bits[IDX_IACC];
        m_dirty    = bits[IDX_DACC];
        m_data_acc = bits[IDX_DACC];
        m_data_dbg = bits[IDX_DDBG];
    end
endmodule

// File: rtl/fault_oneshot_ctrl.sv
module fault_oneshot_ctrl
    import fos_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_load,
    input  logic [NBITS-1:0] ret_bits,
    input  logic             insn_done,
    input  logic             insn_fault,
    input  logic             stk_done,
    input  logic             stk_fault,
    input  logic             mode_br,
    input  logic             var_mode,
    output logic [NBITS-1:0] live_bits,
    output logic             mask_insn_dbg,
    output logic             mask_insn_acc,
    output logic             mask_dirty,
    output logic             mask_data_acc,
    output logic             mask_data_dbg
);
    logic insn_ok, stk_ok, entry_clr;

    assign insn_ok = insn_done & ~insn_fault;
    assign stk_ok  = stk_done & ~stk_fault;

    fos_entry_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (ret_load | mode_br),
        .var_mode  (var_mode),
        .entry_clr (entry_clr)
    );

    fos_bit_bank #(.W(NBITS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ret_load),
        .load_val  (ret_bits),
        .insn_ok   (insn_ok),
        .stk_ok    (stk_ok),
        .entry_clr (entry_clr),
        .bits      (live_bits)
    );

    fos_mask_map u_mask (
        .bits       (live_bits),
        .m_insn_dbg (mask_insn_dbg),
        .m_insn_acc (mask_insn_acc),
        .m_dirty    (mask_dirty),
        .m_data_acc (mask_data_acc),
        .m_data_dbg (mask_data_dbg)
    );

    // R5: faulted completions with no other event leave the bits alone
    p_fault_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_load && !entry_clr && !insn_ok && !stk_ok && (insn_fault || stk_fault))
        |=> $stable(live_bits));
    // R6: load wins over a same-cycle completion
    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_load && (insn_ok || stk_ok)) |=> live_bits == $past(ret_bits));
endmodule

// File: tb/fault_oneshot_ctrl_test.sv
`timescale 1ns/1ps
module fault_oneshot_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ret_load, insn_done, insn_fault, stk_done, stk_fault, mode_br, var_mode;
    logic [3:0] ret_bits;
    logic [3:0] live_bits;
    logic       mask_insn_dbg, mask_insn_acc, mask_dirty, mask_data_acc, mask_data_dbg;
    int         vectors = 0;
    int         miscompares = 0;

    always #5 clk = ~clk;

    fault_oneshot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ret_load(ret_load), .ret_bits(ret_bits),
        .insn_done(insn_done), .insn_fault(insn_fault), .stk_done(stk_done),
        .stk_fault(stk_fault), .mode_br(mode_br), .var_mode(var_mode),
        .live_bits(live_bits), .mask_insn_dbg(mask_insn_dbg),
        .mask_insn_acc(mask_insn_acc), .mask_dirty(mask_dirty),
        .mask_data_acc(mask_data_acc), .mask_data_dbg(mask_data_dbg)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] masks();
        return {mask_data_dbg, mask_data_acc, mask_dirty, mask_insn_acc, mask_insn_dbg};
    endfunction

    // drive at the falling edge, let one rising edge pass, strobes drop 1 ns later
    task automatic cyc(input logic rl, input logic [3:0] rb, input logic idn, input logic ifl,
                       input logic sdn, input logic sfl, input logic mb);
        @(negedge clk);
        ret_load = rl; ret_bits = rb; insn_done = idn; insn_fault = ifl;
        stk_done = sdn; stk_fault = sfl; mode_br = mb;
        @(posedge clk); #1;
        ret_load = 0; insn_done = 0; insn_fault = 0; stk_done = 0; stk_fault = 0; mode_br = 0;
    endtask

    task automatic idle();
        cyc(0, 4'h0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R1 bits", {1'b0, live_bits}, 5'b0);
        chk("R1 masks", masks(), 5'b0);
    endtask

    task automatic t_load_and_faults();
        var_mode = 0;
        cyc(1, 4'b1111, 0, 0, 0, 0, 0);
        chk("R2 load", {1'b0, live_bits}, 5'b01111);
        chk("R9 masks all", masks(), 5'b11111);
        idle();
        chk("R8 bundled no clear", {1'b0, live_bits}, 5'b01111);
        var_mode = 1; idle(); idle();
        chk("R8 late mode rise", {1'b0, live_bits}, 5'b01111);
        var_mode = 0;
        cyc(0, 4'h0, 1, 1, 0, 0, 0);
        chk("R5 insn fault", {1'b0, live_bits}, 5'b01111);
        cyc(0, 4'h0, 0, 0, 1, 1, 0);
        chk("R5 stk fault", {1'b0, live_bits}, 5'b01111);
        cyc(0, 4'h0, 0, 0, 1, 0, 0);
        chk("R4 stk ok", {1'b0, live_bits}, 5'b00101);
        chk("R9 masks 0101", masks(), 5'b00011);
        cyc(0, 4'h0, 1, 0, 0, 0, 0);
        chk("R3 insn ok", {1'b0, live_bits}, 5'b00000);
    endtask

    task automatic t_return_into_var();
        var_mode = 1;
        cyc(1, 4'b1111, 0, 0, 0, 0, 0);
        chk("R2 load var", {1'b0, live_bits}, 5'b01111);
        idle();
        chk("R7 flush on return", {1'b0, live_bits}, 5'b00001);
        chk("R9 masks idbg only", masks(), 5'b00001);
        cyc(0, 4'h0, 1, 0, 0, 0, 0);
        chk("R3 idbg clears", {1'b0, live_bits}, 5'b00000);
    endtask

    task automatic t_mode_branch();
        var_mode = 0;
        cyc(1, 4'b1110, 0, 0, 0, 0, 0);
        idle();
        chk("R8 bundled keep", {1'b0, live_bits}, 5'b01110);
        var_mode = 1;
        cyc(0, 4'h0, 0, 0, 0, 0, 1);
        chk("R7 before flush", {1'b0, live_bits}, 5'b01110);
        idle();
        chk("R7 flush on branch", {1'b0, live_bits}, 5'b00000);
    endtask

    task automatic t_priority();
        var_mode = 0;
        cyc(1, 4'b1010, 1, 0, 1, 0, 0);
        chk("R6 load wins", {1'b0, live_bits}, 5'b01010);
        chk("R9 masks 1010", masks(), 5'b11100);
        idle();
        cyc(0, 4'h0, 0, 0, 1, 0, 0);
        chk("R4 stk clears data", {1'b0, live_bits}, 5'b00000);
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 0; ret_load = 0; ret_bits = 0; insn_done = 0; insn_fault = 0;
        stk_done = 0; stk_fault = 0; mode_br = 0; var_mode = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_load_and_faults();
        t_return_into_var();
        t_mode_branch();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule